// File: doc/BRIEF.md
# Chained Serial Converter Command Receiver

This block receives commands for two dual-channel 13-bit converter controllers that sit one after the other on a single three-wire serial link. Both controllers share one active-low chip select and one serial clock. While chip select is low, every rising serial clock edge moves the data bit into the near controller. The near controller's oldest bit moves on into the far controller. Together they form a 32-bit path, and the far controller's serial output is the chain output.

When chip select returns high after exactly 32 clock edges, each controller decodes the 16-bit word it holds. A word may write one of the controller's two 13-bit channel registers. A frame of any other length is thrown away, and a one-cycle error pulse is raised. The serial pins are oversampled by a faster system clock, so each SCLK phase must last several system clock cycles. A host can read the chain output back to confirm that the link is wired end to end.

Top module: `sdc_chain_rx`

## Requirements
- R1: After reset, all four channel outputs are zero, `dout` is 0 and `frame_err` is 0.
- R2: Bits are taken on rising SCLK edges while `cs_n` is low, most significant bit first. Of a 32-bit frame, the first 16 bits form the word for the far controller (`far_ch0`/`far_ch1`) and the last 16 bits form the word for the near controller (`near_ch0`/`near_ch1`).
- R3: In each 16-bit word, bit 15 selects the channel (0 picks ch0, 1 picks ch1), bits 14:13 are the control code, and bits 12:0 are the data. A command writes at most one channel.
- R4: Control code 2'b00 loads the data into the selected channel. Codes 01, 10 and 11 leave both channels of that controller unchanged.
- R5: Commands take effect only on the rising edge of `cs_n`, and only when exactly 32 rising SCLK edges were seen since `cs_n` fell.
- R6: When `cs_n` rises after any count other than 32 (fewer, more or none), all four channels keep their values and `frame_err` is high for exactly one clock cycle. A valid frame raises no pulse.
- R7: `dout` changes only on falling SCLK edges while `cs_n` is low. Each bit appears on `dout` at the falling edge that follows the 32nd rising edge after the bit entered, counted across frames. Bits not yet pushed through read as 0.
- R8: SCLK edges while `cs_n` is high do nothing. They do not move bits, do not change `dout` and do not count toward the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select that frames a load session |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data into the near controller |
| dout | output | 1 | Serial data out of the far controller |
| frame_err | output | 1 | One-cycle pulse when a frame of the wrong length ends |
| near_ch0 | output | 13 | Near controller, channel 0 value |
| near_ch1 | output | 13 | Near controller, channel 1 value |
| far_ch0 | output | 13 | Far controller, channel 0 value |
| far_ch1 | output | 13 | Far controller, channel 1 value |

## Verification
The hardest behaviour to reach is the chain output, because a bit shows up on `dout` only after 31 more bits have gone in behind it, often in a later frame. The stimulus therefore keeps a running record of every bit shifted while chip select is low, and checks `dout` after every falling edge. Malformed frames are mixed in at random: short, long and empty ones. Bursts of clock edges while chip select is high are also added, so that a good frame following them shows that neither the bit count nor the record was disturbed.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int WORD_W = 16;
  localparam int CTRL_W = 2;
  localparam int DATA_W = 13;
  localparam int N_DEV  = 2;
  localparam int CHAIN_BITS = WORD_W * N_DEV;

  localparam logic [CTRL_W-1:0] CTRL_LOAD = '0;

  typedef struct packed {
    logic              sel;
    logic [CTRL_W-1:0] ctrl;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb pipe_d = d_i;
    end else begin : g_multi
      always_comb pipe_d = {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sdc_stage.sv
module sdc_stage
  import sdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              out_en,
  input  logic              commit,
  input  logic              sin,
  output logic              so,
  output logic [DATA_W-1:0] ch0,
  output logic [DATA_W-1:0] ch1
);
  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic              so_q, so_d;
  logic [DATA_W-1:0] ch0_q, ch0_d, ch1_q, ch1_d;
  cmd_t              cmd;

  assign cmd = cmd_t'(sreg_q);

  always_comb begin
    sreg_d = sreg_q;
    so_d   = so_q;
    ch0_d  = ch0_q;
    ch1_d  = ch1_q;
    if (shift_en) sreg_d = {sreg_q[WORD_W-2:0], sin};
    if (out_en)   so_d   = sreg_q[WORD_W-1];
    if (commit && cmd.ctrl == CTRL_LOAD) begin
      if (cmd.sel) ch1_d = cmd.data;
      else         ch0_d = cmd.data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      so_q   <= 1'b0;
      ch0_q  <= '0;
      ch1_q  <= '0;
    end else begin
      sreg_q <= sreg_d;
      so_q   <= so_d;
      ch0_q  <= ch0_d;
      ch1_q  <= ch1_d;
    end
  end

  assign so  = so_q;
  assign ch0 = ch0_q;
  assign ch1 = ch1_q;

  // R3: one command never writes both channels
  assert_one_ch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !((ch0_q != $past(ch0_q)) && (ch1_q != $past(ch1_q))));
  // R4/R5: channels only move after a commit
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({ch0_q, ch1_q}));
  // R7: serial output moves only on a falling-edge enable
  assert_so_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> $stable(so_q));
endmodule

// File: rtl/sdc_chain_rx.sv
module sdc_chain_rx
  import sdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              frame_err,
  output logic [DATA_W-1:0] near_ch0,
  output logic [DATA_W-1:0] near_ch1,
  output logic [DATA_W-1:0] far_ch0,
  output logic [DATA_W-1:0] far_ch1
);
  localparam int CNT_MAX = CHAIN_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic cs_lvl, sclk_lvl, din_lvl;
  sdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cs
    (.clk(clk), .rst_n(rst_q), .d_i(cs_n), .q_o(cs_lvl));
  sdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sclk
    (.clk(clk), .rst_n(rst_q), .d_i(sclk), .q_o(sclk_lvl));
  sdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_din
    (.clk(clk), .rst_n(rst_q), .d_i(din), .q_o(din_lvl));

  logic cs_prev_q, sclk_prev_q;
  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic shift_en, out_en, commit, err_d, err_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign cs_rise   =  cs_lvl   & ~cs_prev_q;
  assign cs_fall   = ~cs_lvl   &  cs_prev_q;
  assign sclk_rise =  sclk_lvl & ~sclk_prev_q;
  assign sclk_fall = ~sclk_lvl &  sclk_prev_q;
  assign shift_en  = sclk_rise & ~cs_lvl;
  assign out_en    = sclk_fall & ~cs_lvl;

  always_comb begin
    cnt_d = cnt_q;
    if (cs_fall) begin
      cnt_d = shift_en ? CNT_W'(1) : '0;
    end else if (shift_en && cnt_q != CNT_W'(CNT_MAX)) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    commit = cs_rise & (cnt_q == CNT_W'(CHAIN_BITS));
    err_d  = cs_rise & (cnt_q != CNT_W'(CHAIN_BITS));
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
      cnt_q       <= '0;
      err_q       <= 1'b0;
    end else begin
      cs_prev_q   <= cs_lvl;
      sclk_prev_q <= sclk_lvl;
      cnt_q       <= cnt_d;
      err_q       <= err_d;
    end
  end

  logic              so_w  [N_DEV];
  logic              sin_w [N_DEV];
  logic [DATA_W-1:0] c0_w  [N_DEV];
  logic [DATA_W-1:0] c1_w  [N_DEV];

  generate
    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
      if (g == 0) begin : g_head
        assign sin_w[g] = din_lvl;
      end else begin : g_link
        assign sin_w[g] = so_w[g-1];
      end
      sdc_stage i_stage (
        .clk(clk), .rst_n(rst_q), .shift_en(shift_en), .out_en(out_en),
        .commit(commit), .sin(sin_w[g]), .so(so_w[g]),
        .ch0(c0_w[g]), .ch1(c1_w[g]));
    end
  endgenerate

  assign dout      = so_w[N_DEV-1];
  assign frame_err = err_q;
  assign near_ch0  = c0_w[0];
  assign near_ch1  = c1_w[0];
  assign far_ch0   = c0_w[N_DEV-1];
  assign far_ch1   = c1_w[N_DEV-1];

  // R5: the edge counter saturates one past a full frame
  assert_cnt_cap_R5: assert property (@(posedge clk) disable iff (!rst_q)
    cnt_q <= CNT_W'(CNT_MAX));
  // R6: the error flag is a single-cycle pulse
  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_q)
    frame_err |=> !frame_err);
  // R6: a rejected frame leaves every channel untouched
  assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_q)
    frame_err |-> $stable({near_ch0, near_ch1, far_ch0, far_ch1}));
  // R8: with chip select high the frame count does not move
  assert_idle_cnt_R8: assert property (@(posedge clk) disable iff (!rst_q)
    cs_lvl |=> $stable(cnt_q));
  // R7: chain output is steady unless a falling edge arrived under select
  assert_dout_fall_R7: assert property (@(posedge clk) disable iff (!rst_q)
    !out_en |=> $stable(dout));
endmodule

// File: tb/test_sdc_chain_rx.sv
`timescale 1ns/1ps
module test_sdc_chain_rx;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic dout, frame_err;
  logic [12:0] near_ch0, near_ch1, far_ch0, far_ch1;

  int total = 0, bad = 0, err_seen = 0;
  bit hist[$];
  logic [12:0] exp_near[2], exp_far[2];

  always #4 clk = ~clk;

  sdc_chain_rx i_sdc_chain_rx (.*);

  always @(negedge clk) if (frame_err) err_seen++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_dout();
    int n = hist.size();
    return (n >= 32) ? hist[n-32] : 1'b0;
  endfunction

  function automatic void apply_word(logic [15:0] w, bit far);
    if (w[14:13] == 2'b00) begin
      if (far) exp_far[w[15]] = w[12:0];
      else     exp_near[w[15]] = w[12:0];
    end
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(logic b, bit selected);
    din = b;
    wait_clk(4);
    sclk = 1'b1;
    wait_clk(8);
    sclk = 1'b0;
    wait_clk(8);
    if (selected) begin
      hist.push_back(b);
      chk("R7", dout, exp_dout(), "dout after falling edge");
    end
  endtask

  task automatic check_channels(string req);
    chk(req, near_ch0, exp_near[0], "near_ch0");
    chk(req, near_ch1, exp_near[1], "near_ch1");
    chk(req, far_ch0, exp_far[0], "far_ch0");
    chk(req, far_ch1, exp_far[1], "far_ch1");
  endtask

  task automatic send_frame(logic [63:0] val, int count);
    int e0 = err_seen;
    cs_n = 1'b0;
    wait_clk(8);
    for (int i = 0; i < count; i++) shift_bit(val[count-1-i], 1'b1);
    cs_n = 1'b1;
    wait_clk(12);
    if (count == 32) begin
      apply_word(val[31:16], 1'b1);
      apply_word(val[15:0], 1'b0);
      check_channels("R2/R4/R5");
      chk("R6", err_seen - e0, 0, "no error on valid frame");
    end else begin
      check_channels("R6");
      chk("R6", err_seen - e0, 1, "single error pulse on bad length");
    end
  endtask

  function automatic logic [15:0] rand_word();
    logic [1:0] c = ($urandom % 2) ? 2'b00 : 2'($urandom % 4);
    return {1'($urandom), c, 13'($urandom)};
  endfunction

  initial begin
    #(8ns * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    exp_near = '{default: '0};
    exp_far  = '{default: '0};
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    check_channels("R1");
    chk("R1", dout, 0, "dout after reset");
    chk("R1", frame_err, 0, "frame_err after reset");

    // R2/R3: distinct values in every channel, upper word goes far
    send_frame({32'h0, 16'h0ABC, 16'h1123}, 32);   // far ch0, near ch0
    send_frame({32'h0, 16'h9FFF, 16'h8001}, 32);   // far ch1, near ch1
    // R4: non-load codes leave channels alone
    send_frame({32'h0, 16'h2555, 16'hE777}, 32);
    send_frame({32'h0, 16'hC111, 16'h4222}, 32);
    // R6: short, long and empty frames
    send_frame(64'hFFFF_FFFF_0000_0000 | 64'h0000_0000_1234_5678, 31);
    send_frame(64'h1_0000_0000, 33);
    send_frame(64'h0, 0);
    // R8: clock edges while deselected are ignored
    cs_n = 1'b1;
    for (int i = 0; i < 6; i++) shift_bit(1'b1, 1'b0);
    chk("R8", dout, exp_dout(), "dout unchanged while deselected");
    check_channels("R8");
    send_frame({32'h0, 16'h0042, 16'h9003}, 32);   // still exactly 32 accepted

    for (int f = 0; f < 40; f++) begin
      int sel = $urandom % 8;
      int cnt = (sel < 5) ? 32 : (sel == 5) ? 31 : (sel == 6) ? 33 : int'($urandom % 31);
      send_frame({32'($urandom), rand_word(), rand_word()}, cnt);
      if ($urandom % 6 == 0) begin
        for (int i = 0; i < 3; i++) shift_bit(1'($urandom), 1'b0);
        chk("R8", dout, exp_dout(), "dout after idle burst");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule